// File: doc/BRIEF.md
# Single-Wire Self-Clocking Register Write Receiver

This block takes register write commands from one idle-high wire and turns each good command into a single-cycle write strobe with a 5-bit address and an 8-bit data byte, ready for a register file. The wire is sampled by a local clock at least twenty times faster than the bit rate. The block needs no fixed baud setting, because every command carries its own timing reference.

A command opens with a wake pair, which is one bit time low and then one bit time high. A calibration pair of the same shape follows, and the receiver measures its length to find the bit period for the rest of the command. Next come a low start bit, the address and the data, both most significant bit first. The command closes with the wire held high for a standby interval. Instead of the standby interval, a new wake pair may follow the last data bit at once, which chains the next command. A command with an impossible calibration or a broken standby interval is dropped. The receiver then waits for the wire to rest high before it listens again.

Top module: `swr_rx`

## Requirements
- R1: While reset is asserted, and after its release until the first accepted command, `wr_en_o` is 0 and `wr_addr_o` and `wr_data_o` are all zeros.
- R2: After the start bit come 5 address bits and then 8 data bits, each most significant bit first. Each bit is read as the wire level at the centre of its slot (low = 0, high = 1), and a strobe presents them on `wr_addr_o` and `wr_data_o`.
- R3: The bit period is measured again for every command from the calibration pair. With 2P clock cycles from the calibration falling edge to the start-bit falling edge, the period is P. Commands are decoded correctly for any P from 20 cycles up to the 75 kbit/s period of a 200 MHz clock (2667 cycles).
- R4: For a command closed by standby, `wr_en_o` is high for exactly one cycle, at clock edge s + 18P + floor(P/2) + 2, where s is the first clock edge that samples the start bit low on `line_i`. This falls within 5P of the end of the last data bit.
- R5: If the wire is low at the centre of the slot after the last data bit, the command is chained. The strobe comes at edge s + 14P + floor(P/2) + 2, and that low is taken as the wake low of the next command, which is then decoded normally.
- R6: If the wire is low at any clock cycle between that post-data centre sample and the standby strobe point, the command is dropped and no strobe is given.
- R7: If the calibration pair lasts fewer than 4 cycles, the command is dropped.
- R8: If the calibration pair lasts 2^CNT_W - 1 cycles or more, the command is dropped.
- R9: After a dropped command, the receiver ignores all line activity until the wire has been high for 2^CNT_W - 1 consecutive cycles. A command sent after that is accepted.
- R10: `wr_addr_o` and `wr_data_o` change only in a cycle in which `wr_en_o` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock, at least 20x the bit rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_i | input | 1 | Single-wire command input, idle high, asynchronous |
| wr_en_o | output | 1 | One-cycle register write strobe |
| wr_addr_o | output | ADDR_W (5) | Register address of the last accepted write |
| wr_data_o | output | DATA_W (8) | Data byte of the last accepted write |

## Verification
Every strobe is due at a cycle fixed by the start-bit edge and the measured period: s + 18P + floor(P/2) + 2 for a command closed by standby, and s + 14P + floor(P/2) + 2 for a chained one. The two-stage input synchronizer is part of the constant 2. The bench records s when it drives the start bit and queues the due cycle together with the address and data. On every falling clock edge it compares `wr_en_o` against the queue, so a strobe that comes one cycle early or late fails, as does any strobe during a dropped or ignored command. Odd and even periods check the floor(P/2) centre point, and a count of strobes after each scenario confirms that dropped commands left no trace.

// File: rtl/swr_pkg.sv
package swr_pkg;

  // Receiver sequencing states
  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,  // line resting high, waiting for wake low
    ST_WAKE_LO = 3'd1,  // inside wake low, waiting for rise
    ST_WAKE_HI = 3'd2,  // inside wake high, waiting for calibration fall
    ST_CAL     = 3'd3,  // measuring the calibration pair
    ST_BITS    = 3'd4,  // sampling start, address, data and post-data slot
    ST_STANDBY = 3'd5,  // guarding the idle-high standby interval
    ST_DROP    = 3'd6   // discarded command, waiting for a long high rest
  } swr_state_e;

endpackage

// File: rtl/swr_sync.sv
module swr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic srst_n_o,
  output logic line_o
);

  logic [STAGES-1:0] rst_pipe_q;
  logic [STAGES-1:0] line_pipe_q;

  // Reset asserts at once and releases after STAGES clock edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[STAGES-2:0], 1'b1};
  end

  // Line resets to its idle (high) level
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) line_pipe_q <= '1;
    else        line_pipe_q <= {line_pipe_q[STAGES-2:0], line_i};
  end

  assign srst_n_o = rst_pipe_q[STAGES-1];
  assign line_o   = line_pipe_q[STAGES-1];

endmodule

// File: rtl/swr_period.sv
module swr_period #(
  parameter int CNT_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             inc_i,
  input  logic             cap_i,
  output logic             full_o,
  output logic [CNT_W-1:0] span_o,
  output logic [CNT_W-1:0] bit_len_o
);

  localparam int CAL_MAX = (1 << CNT_W) - 1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] bit_len_q, bit_len_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)      cnt_d = '0;
    else if (inc_i) cnt_d = cnt_q + 1'b1;
  end

  // Cycles spanned by the pair, counting the cycle of the closing edge
  assign span_o = cnt_q + 1'b1;
  assign full_o = (cnt_q == CNT_W'(CAL_MAX - 1));

  always_comb begin
    bit_len_d = bit_len_q;
    if (cap_i) bit_len_d = span_o >> 1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      bit_len_q <= '0;
    end else begin
      cnt_q     <= cnt_d;
      bit_len_q <= bit_len_d;
    end
  end

  assign bit_len_o = bit_len_q;

endmodule

// File: rtl/swr_timer.sv
module swr_timer #(
  parameter int W = 15
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         dec_i,
  output logic         zero_o
);

  logic [W-1:0] t_q, t_d;

  assign zero_o = (t_q == '0);

  always_comb begin
    t_d = t_q;
    if (load_i)              t_d = load_val_i;
    else if (dec_i && !zero_o) t_d = t_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) t_q <= '0;
    else        t_q <= t_d;
  end

endmodule

// File: rtl/swr_shift.sv
module swr_shift #(
  parameter int W = 13
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en_i,
  input  logic         bit_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] sh_q, sh_d;

  always_comb begin
    sh_d = sh_q;
    if (en_i) sh_d = {sh_q[W-2:0], bit_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign q_o = sh_q;

endmodule

// File: rtl/swr_rx.sv
module swr_rx
  import swr_pkg::*;
#(
  parameter int CNT_W       = 14,
  parameter int ADDR_W      = 5,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_i,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o
);

  localparam int FRAME_W   = ADDR_W + DATA_W;
  localparam int CHECK_IDX = FRAME_W + 1;
  localparam int IDX_W     = $clog2(CHECK_IDX + 1);
  localparam int TMR_W     = CNT_W + 1;

  logic srst_n, ln;

  swr_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .line_i(line_i), .srst_n_o(srst_n), .line_o(ln)
  );

  // Control from the sequencer
  logic             cnt_clr, cnt_inc, cap;
  logic             tmr_load, tmr_dec, tmr_zero;
  logic [TMR_W-1:0] tmr_val;
  logic             sh_en;
  logic             cnt_full;
  logic [CNT_W-1:0] span, bit_len;
  logic [FRAME_W-1:0] frame;

  swr_period #(.CNT_W(CNT_W)) u_period (
    .clk(clk), .rst_n(srst_n), .clr_i(cnt_clr), .inc_i(cnt_inc), .cap_i(cap),
    .full_o(cnt_full), .span_o(span), .bit_len_o(bit_len)
  );

  swr_timer #(.W(TMR_W)) u_timer (
    .clk(clk), .rst_n(srst_n), .load_i(tmr_load), .load_val_i(tmr_val),
    .dec_i(tmr_dec), .zero_o(tmr_zero)
  );

  swr_shift #(.W(FRAME_W)) u_shift (
    .clk(clk), .rst_n(srst_n), .en_i(sh_en), .bit_i(ln), .q_o(frame)
  );

  // Timer reload values derived from the measured pair
  logic [TMR_W-1:0] span_w, bit_w, half_m1, bit_m1, stby_m1;
  assign span_w  = TMR_W'(span);
  assign bit_w   = TMR_W'(bit_len);
  assign half_m1 = (span_w >> 2) - 1'b1;
  assign bit_m1  = bit_w - 1'b1;
  assign stby_m1 = (bit_w << 2) - 1'b1;

  swr_state_e        st_q, st_d;
  logic              seen_q, seen_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic              wr_d;
  logic              wr_q;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [DATA_W-1:0] data_q, data_d;

  always_comb begin
    st_d     = st_q;
    seen_d   = seen_q;
    idx_d    = idx_q;
    cnt_clr  = 1'b0;
    cnt_inc  = 1'b0;
    cap      = 1'b0;
    tmr_load = 1'b0;
    tmr_val  = '0;
    tmr_dec  = 1'b0;
    sh_en    = 1'b0;
    wr_d     = 1'b0;
    unique case (st_q)
      ST_IDLE:    if (!ln) st_d = ST_WAKE_LO;
      ST_WAKE_LO: if (ln)  st_d = ST_WAKE_HI;
      ST_WAKE_HI: if (!ln) begin
        st_d    = ST_CAL;
        cnt_clr = 1'b1;
        seen_d  = 1'b0;
      end
      ST_CAL: begin
        if (cnt_full) begin
          st_d    = ST_DROP;
          cnt_clr = 1'b1;
        end else if (seen_q && !ln) begin
          if (span < CNT_W'(4)) begin
            st_d    = ST_DROP;
            cnt_clr = 1'b1;
          end else begin
            st_d     = ST_BITS;
            cap      = 1'b1;
            tmr_load = 1'b1;
            tmr_val  = half_m1;
            idx_d    = '0;
          end
        end else begin
          cnt_inc = 1'b1;
          if (ln) seen_d = 1'b1;
        end
      end
      ST_BITS: begin
        if (!tmr_zero) begin
          tmr_dec = 1'b1;
        end else if (idx_q == IDX_W'(CHECK_IDX)) begin
          if (!ln) begin
            wr_d = 1'b1;
            st_d = ST_WAKE_LO;
          end else begin
            st_d     = ST_STANDBY;
            tmr_load = 1'b1;
            tmr_val  = stby_m1;
          end
        end else begin
          tmr_load = 1'b1;
          tmr_val  = bit_m1;
          idx_d    = idx_q + 1'b1;
          sh_en    = (idx_q != '0);
        end
      end
      ST_STANDBY: begin
        if (!ln) begin
          st_d    = ST_DROP;
          cnt_clr = 1'b1;
        end else if (tmr_zero) begin
          wr_d = 1'b1;
          st_d = ST_IDLE;
        end else begin
          tmr_dec = 1'b1;
        end
      end
      ST_DROP: begin
        if (!ln)           cnt_clr = 1'b1;
        else if (cnt_full) st_d    = ST_IDLE;
        else               cnt_inc = 1'b1;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_comb begin
    addr_d = addr_q;
    data_d = data_q;
    if (wr_d) begin
      addr_d = frame[FRAME_W-1 -: ADDR_W];
      data_d = frame[DATA_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      st_q   <= ST_IDLE;
      seen_q <= 1'b0;
      idx_q  <= '0;
      wr_q   <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      st_q   <= st_d;
      seen_q <= seen_d;
      idx_q  <= idx_d;
      wr_q   <= wr_d;
      addr_q <= addr_d;
      data_q <= data_d;
    end
  end

  assign wr_en_o   = wr_q;
  assign wr_addr_o = addr_q;
  assign wr_data_o = data_q;

endmodule

// File: rtl/swr_rx_chk.sv
module swr_rx_chk
  import swr_pkg::*;
#(
  parameter int CNT_W  = 14,
  parameter int ADDR_W = 5,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input swr_state_e        st,
  input logic [CNT_W-1:0]  bit_len
);

  always @(posedge clk) begin
    if (!rst_n) begin
      AST_RESET_QUIET: assert (!wr_en && wr_addr == '0 && wr_data == '0); // R1
    end
  end

  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en); // R4

  AST_FIELDS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |-> ($stable(wr_addr) && $stable(wr_data))); // R10

  AST_DROP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_DROP) |-> !wr_en); // R6

  AST_PERIOD_USABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_BITS) |-> (bit_len >= CNT_W'(2))); // R7

  AST_CHAIN_REARMS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && $past(st) == ST_BITS) |-> (st == ST_WAKE_LO || st == ST_WAKE_HI)); // R5

endmodule

bind swr_rx swr_rx_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en_o), .wr_addr(wr_addr_o),
  .wr_data(wr_data_o), .st(st_q), .bit_len(bit_len)
);

// File: tb/tb_swr_rx.sv
module tb_swr_rx;

  localparam int  CW       = 13;
  localparam int  CAL_MAX  = (1 << CW) - 1;
  localparam longint WD_LIMIT = 190000;

  logic       clk;
  logic       rst_n;
  logic       line;
  logic       wr_en;
  logic [4:0] wr_addr;
  logic [7:0] wr_data;

  swr_rx #(.CNT_W(CW)) dut (
    .clk(clk), .rst_n(rst_n), .line_i(line),
    .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;  // 200 MHz

  longint cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk  = 0;
  int n_fail = 0;
  int n_seen = 0;
  string cur_tag = "R1";

  // Expected strobes: due cycle, address, data, requirement
  longint qc[$];
  int     qa[$];
  int     qd[$];
  string  qt[$];

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", tag, what, act, expv, cyc);
    end
  endtask

  // Per-cycle reference comparison
  always @(negedge clk) begin
    if (rst_n) begin
      if (wr_en) n_seen++;
      if (qc.size() > 0 && qc[0] == cyc) begin
        chk(wr_en === 1'b1, qt[0], "strobe", longint'(wr_en), 1);
        chk(wr_addr === 5'(qa[0]), "R2", "address", longint'(wr_addr), qa[0]);
        chk(wr_data === 8'(qd[0]), "R2", "data", longint'(wr_data), qd[0]);
        void'(qc.pop_front()); void'(qa.pop_front());
        void'(qd.pop_front()); void'(qt.pop_front());
      end else begin
        chk(wr_en === 1'b0, cur_tag, "unexpected strobe", longint'(wr_en), 0);
      end
    end
  end

  task automatic hold(input logic v, input int n);
    line = v;
    repeat (n) @(negedge clk);
  endtask

  // mode 0: standby close, 1: chained, 2: standby broken, 3: sent while ignored
  task automatic send_frame(input int t, input int a, input int d, input int mode,
                            input string tag);
    longint s;
    hold(1'b0, t); hold(1'b1, t);
    hold(1'b0, t); hold(1'b1, t);
    s = cyc + 1;
    hold(1'b0, t);
    for (int i = 4; i >= 0; i--) hold(a[i], t);
    for (int i = 7; i >= 0; i--) hold(d[i], t);
    if (mode == 0 || mode == 1) begin
      qc.push_back(mode == 1 ? s + 14*t + t/2 + 2 : s + 18*t + t/2 + 2);
      qa.push_back(a); qd.push_back(d); qt.push_back(tag);
    end
    if (mode == 0 || mode == 3) hold(1'b1, 5*t);
    if (mode == 2) begin
      hold(1'b1, 2*t);
      hold(1'b0, t);
      line = 1'b1;
    end
  endtask

  task automatic count_check(input int base, input int expn, input string tag);
    chk(n_seen - base == expn, tag, "strobe count", n_seen - base, expn);
  endtask

  task automatic finish_run;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    if (cyc == WD_LIMIT) begin
      n_chk++; n_fail++;
      $display("FAIL R4 watchdog: actual %0d expected %0d", cyc, 0);
      finish_run();
    end
  end

  initial begin
    int base;
    line  = 1'b1;
    rst_n = 1'b0;
    repeat (5) @(negedge clk);
    // R1: quiet outputs during reset
    chk(wr_en === 1'b0, "R1", "reset wr_en", longint'(wr_en), 0);
    chk(wr_addr === 5'd0, "R1", "reset addr", longint'(wr_addr), 0);
    chk(wr_data === 8'd0, "R1", "reset data", longint'(wr_data), 0);
    rst_n = 1'b1;
    hold(1'b1, 30);
    chk(wr_en === 1'b0 && wr_addr === 5'd0, "R1", "idle after reset", longint'(wr_addr), 0);

    // R2 / R4: minimum oversampling, standby close
    cur_tag = "R4"; base = n_seen;
    send_frame(20, 'h15, 'hA5, 0, "R4");
    hold(1'b1, 40);
    count_check(base, 1, "R2");

    // R3: odd period, centre at floor(P/2)
    cur_tag = "R3"; base = n_seen;
    send_frame(33, 'h0A, 'h3C, 0, "R3");
    send_frame(27, 'h11, 'h5E, 0, "R3");
    hold(1'b1, 40);
    count_check(base, 2, "R3");

    // R5: chained, last data bit 0 then 1
    cur_tag = "R5"; base = n_seen;
    send_frame(24, 'h01, 'h80, 1, "R5");
    send_frame(24, 'h1F, 'hFF, 1, "R5");
    send_frame(24, 'h00, 'h00, 0, "R5");
    hold(1'b1, 40);
    count_check(base, 3, "R5");

    // R6 then R9: broken standby, frame during rest ignored, then recovery
    cur_tag = "R6"; base = n_seen;
    send_frame(20, 'h0C, 'h77, 2, "R6");
    hold(1'b1, 20);
    count_check(base, 0, "R6");
    cur_tag = "R9"; base = n_seen;
    send_frame(20, 'h13, 'h42, 3, "R9");
    hold(1'b1, CAL_MAX + 50);
    count_check(base, 0, "R9");
    send_frame(25, 'h07, 'hC3, 0, "R9");
    hold(1'b1, 40);
    count_check(base, 1, "R9");

    // R7: calibration pair far too short
    cur_tag = "R7"; base = n_seen;
    hold(1'b0, 20); hold(1'b1, 20);
    hold(1'b0, 1);  hold(1'b1, 1);
    hold(1'b0, 20); hold(1'b1, CAL_MAX + 50);
    count_check(base, 0, "R7");

    // R8: calibration pair past the counter limit, then R9 recovery
    cur_tag = "R8"; base = n_seen;
    hold(1'b0, 20); hold(1'b1, 20);
    hold(1'b0, 4100); hold(1'b1, 4100 + CAL_MAX + 50);
    count_check(base, 0, "R8");
    cur_tag = "R9"; base = n_seen;
    send_frame(22, 'h19, 'h6D, 0, "R9");
    hold(1'b1, 40);
    count_check(base, 1, "R9");

    // R3: slowest supported period (75 kbit/s at 200 MHz)
    cur_tag = "R3"; base = n_seen;
    send_frame(2667, 'h16, 'h9B, 0, "R3");
    hold(1'b1, 40);
    count_check(base, 1, "R3");

    chk(qc.size() == 0, "R4", "pending strobes", qc.size(), 0);
    finish_run();
  end

endmodule